// File: doc/BRIEF.md
# Security-Gated Power Control Register Bank

This block holds the software-visible control state of a power-management controller. A simple bus slave port carries the address, write data, separate write and read strobes and a per-access secure attribute. The block answers each access with a registered ready pulse, read data and an error flag. A global security-enable input decides whether writes marked non-secure are filtered. Each register has its own policy: reject with an error, always accept, or filter bit by bit.

A backup-domain register is locked unless an unlock bit in the main control register is set. Writes to a locked register are dropped without any error. Writes to the slower registers are held for a fixed number of wait states. A write that clears wakeup flags does not finish until the targeted flags have really dropped.

Registers sit in three reset groups: system, application and power-on. Identification words fill the last three words of the address window.

Top module: `pm_secure_regs`

## Requirements
- R1: After power-on reset, every register reads zero and the register output ports are zero.
- R2: A read is granted whatever the secure attribute and the security enable. It returns the current value with ready one cycle after the read is presented, and with no error.
- R3: While `sec_en` is high, a non-secure write to a guarded register is answered one cycle later with ready and error, and the register keeps its value. The guarded registers are main control (0x00), backup (0x04) and wake-secure (0x14).
- R4: The auxiliary register (0x08) accepts non-secure writes even while `sec_en` is high, and raises no error.
- R5: Writes to main control, to the read-only words and to unmapped addresses complete one cycle after they are presented. Writes to backup, auxiliary, wake-config (0x0C) and wake-secure complete WS+1 cycles after they are presented (7 by default).
- R6: Wake-config layout for pin p (0..NPIN-1): clear bit at p, polarity at 8+p, pull field at 16+2p..17+2p. Clear bits read as zero. While `sec_en` is high, a non-secure write leaves unchanged the polarity, pull and clear of every pin whose bit p in wake-secure (0x14, bit p per pin) is set, and raises no error.
- R7: The backup register changes only on writes made while bit 0 of main control is 1. Writes made while that bit is 0 have no effect, raise no error and still take WS+1 cycles.
- R8: A wake-config write with at least one permitted clear bit finishes WS+2 cycles after it is presented, provided the targeted flags drop at commit. Ready is withheld for as long as any targeted flag is still set.
- R9: The wake-flag register (0x10, bit p per pin) is read-only. It ignores writes, which complete in one cycle with no error. A high `wake_pulse[p]` at a clock edge sets flag p. A flag falls only through a permitted clear. When set and clear meet at the same edge, set wins.
- R10: `sys_rst` clears main control and auxiliary only. `app_rst` also clears wake-config, wake-flag and wake-secure. Only `por_rst` clears backup.
- R11: Reads at 0x3F4, 0x3F8 and 0x3FC return VER_VAL, IDN_VAL and SIZE_VAL. Writes there change nothing.
- R12: Unmapped and unaligned addresses read zero and ignore writes, with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, clears all groups |
| app_rst | input | 1 | Application reset, clears system and wake groups |
| sys_rst | input | 1 | System reset, clears system group |
| sec_en | input | 1 | Enables filtering of non-secure writes |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data, held until ready |
| bus_wr | input | 1 | Write request, held until ready |
| bus_rd | input | 1 | Read request, held until ready |
| bus_secure | input | 1 | 1 = secure access |
| bus_rdata | output | DW | Read data, valid with ready |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Error response, valid with ready |
| wake_pulse | input | NPIN | Per-pin flag set pulses |
| ctrl_q | output | DW | Main control register; bit 0 unlocks backup |
| bkup_q | output | DW | Backup register |
| aux_q | output | DW | Auxiliary register |
| wake_pol | output | NPIN | Per-pin polarity |
| wake_pull | output | 2*NPIN | Per-pin pull fields |
| wake_flags | output | NPIN | Wakeup flags |
| wake_secure | output | NPIN | Per-pin secure enables |

## Verification
The hardest case to reach is a flag set pulse that lands on the very edge where a clear write commits. The pulse has to hit one particular cycle deep inside the wait-state window. The stimulus forks the bus write alongside a timer that raises `wake_pulse` exactly WS negative edges after the request. The scoreboard then expects one extra cycle of latency and the flag low at the end. Masked non-secure writes are checked by reading back the mixed result, where protected pins keep their old fields and open pins take the new ones.

// File: rtl/pmsr_pkg.sv
package pmsr_pkg;
  typedef enum logic [3:0] {
    S_CTRL, S_BKUP, S_AUX, S_WKCFG, S_WKFLG, S_WKSEC, S_VER, S_IDN, S_SIZE, S_NONE
  } sel_e;

  typedef enum logic [1:0] {P_GUARD, P_OPEN, P_PERBIT, P_RDONLY} pol_e;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CLR} st_e;

  localparam logic [31:0] OFS_CTRL  = 32'h00;
  localparam logic [31:0] OFS_BKUP  = 32'h04;
  localparam logic [31:0] OFS_AUX   = 32'h08;
  localparam logic [31:0] OFS_WKCFG = 32'h0C;
  localparam logic [31:0] OFS_WKFLG = 32'h10;
  localparam logic [31:0] OFS_WKSEC = 32'h14;

  localparam int POL_LSB  = 8;
  localparam int PULL_LSB = 16;
endpackage

// File: rtl/pmsr_decode.sv
module pmsr_decode
  import pmsr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW-1:0] addr,
  output sel_e          sel,
  output pol_e          pol,
  output logic          slow
);
  localparam logic [31:0] WIN     = 32'(1) << AW;
  localparam logic [31:0] OFS_VER = WIN - 32'd12;
  localparam logic [31:0] OFS_IDN = WIN - 32'd8;
  localparam logic [31:0] OFS_SZ  = WIN - 32'd4;

  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    if      (a32 == OFS_CTRL)  sel = S_CTRL;
    else if (a32 == OFS_BKUP)  sel = S_BKUP;
    else if (a32 == OFS_AUX)   sel = S_AUX;
    else if (a32 == OFS_WKCFG) sel = S_WKCFG;
    else if (a32 == OFS_WKFLG) sel = S_WKFLG;
    else if (a32 == OFS_WKSEC) sel = S_WKSEC;
    else if (a32 == OFS_VER)   sel = S_VER;
    else if (a32 == OFS_IDN)   sel = S_IDN;
    else if (a32 == OFS_SZ)    sel = S_SIZE;
    else                       sel = S_NONE;
  end

  always_comb begin
    pol  = P_RDONLY;
    slow = 1'b0;
    unique case (sel)
      S_CTRL:  pol = P_GUARD;
      S_BKUP:  begin pol = P_GUARD;  slow = 1'b1; end
      S_AUX:   begin pol = P_OPEN;   slow = 1'b1; end
      S_WKCFG: begin pol = P_PERBIT; slow = 1'b1; end
      S_WKSEC: begin pol = P_GUARD;  slow = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pmsr_seq.sv
module pmsr_seq
  import pmsr_pkg::*;
#(
  parameter int WS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic rd,
  input  logic reject,
  input  logic slow,
  input  logic clr_need,
  input  logic clr_done,
  output logic ready,
  output logic err,
  output logic commit,
  output logic release_clr,
  output logic rd_take
);
  localparam int CW = (WS < 1) ? 1 : $clog2(WS + 1);
  localparam logic [CW-1:0] LAST = CW'(WS - 1);

  st_e           state;
  logic [CW-1:0] cnt;
  logic          idle_free;

  assign idle_free   = (state == ST_IDLE) && !ready;
  assign rd_take     = idle_free && rd;
  assign commit      = (idle_free && wr && !rd && !reject && !slow) ||
                       ((state == ST_WAIT) && (cnt == LAST));
  assign release_clr = (state == ST_CLR) && clr_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      ready <= 1'b0;
      err   <= 1'b0;
    end else begin
      ready <= 1'b0;
      err   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (rd_take) begin
            ready <= 1'b1;
          end else if (idle_free && wr) begin
            if (reject) begin
              ready <= 1'b1;
              err   <= 1'b1;
            end else if (slow) begin
              state <= ST_WAIT;
              cnt   <= '0;
            end else begin
              ready <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (cnt == LAST) begin
            if (clr_need) state <= ST_CLR;
            else begin
              state <= ST_IDLE;
              ready <= 1'b1;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_CLR: begin
          if (clr_done) begin
            state <= ST_IDLE;
            ready <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: reads answer in one cycle, never with an error
  a_r2_read_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rd_take |=> (ready && !err));
  // R3: an error is only ever reported together with ready
  a_r3_err_with_ready: assert property (@(posedge clk) disable iff (rst)
    err |-> ready);
  // R5: no completion while wait states are being counted
  a_r5_hold_in_wait: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !ready);
  // R8: no completion while a flag clear is outstanding
  a_r8_hold_in_clear: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLR) |-> !ready);
endmodule

// File: rtl/pmsr_wake.sv
module pmsr_wake #(
  parameter int NPIN = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ns_filter,
  input  logic              sel_cfg,
  input  logic              wr_cfg,
  input  logic              wr_sec,
  input  logic [NPIN-1:0]   clr_bits,
  input  logic [NPIN-1:0]   pol_bits,
  input  logic [2*NPIN-1:0] pull_bits,
  input  logic [NPIN-1:0]   sec_bits,
  input  logic [NPIN-1:0]   wake_pulse,
  input  logic              release_clr,
  output logic [NPIN-1:0]   flags,
  output logic [NPIN-1:0]   secen,
  output logic [NPIN-1:0]   pol,
  output logic [2*NPIN-1:0] pull,
  output logic              clr_need,
  output logic              clr_done
);
  logic [NPIN-1:0] allow, clr_req, clr_now, pend;

  assign allow    = ~(secen & {NPIN{ns_filter}});
  assign clr_req  = clr_bits & allow;
  assign clr_need = sel_cfg && (|clr_req);
  assign clr_now  = wr_cfg ? clr_req : pend;
  assign clr_done = (flags & pend) == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      pend  <= '0;
      secen <= '0;
    end else begin
      flags <= (flags & ~clr_now) | wake_pulse;
      if (wr_cfg)           pend <= clr_req;
      else if (release_clr) pend <= '0;
      if (wr_sec)           secen <= sec_bits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol  <= '0;
      pull <= '0;
    end else if (wr_cfg) begin
      for (int p = 0; p < NPIN; p++) begin
        if (allow[p]) begin
          pol[p]        <= pol_bits[p];
          pull[2*p +: 2] <= pull_bits[2*p +: 2];
        end
      end
    end
  end

  // R9: a set pulse always leaves its flag high at the next edge
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|wake_pulse) |=> ((flags & $past(wake_pulse)) == $past(wake_pulse)));
  // R9: flags cannot fall unless a clear is being applied
  a_r9_no_spurious_fall: assert property (@(posedge clk) disable iff (rst)
    (!wr_cfg && pend == '0) |=> ((~flags & $past(flags)) == '0));
  // R6: protected pins keep their polarity across a filtered write
  a_r6_masked_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && ns_filter) |=> (((pol ^ $past(pol)) & $past(secen)) == '0));
endmodule

// File: rtl/pm_secure_regs.sv
module pm_secure_regs
  import pmsr_pkg::*;
#(
  parameter int              AW       = 10,
  parameter int              DW       = 32,
  parameter int              NPIN     = 6,
  parameter int              WS       = 6,
  parameter logic [DW-1:0]   VER_VAL  = 'h0000_0012,
  parameter logic [DW-1:0]   IDN_VAL  = 'h0031_5057,
  parameter logic [DW-1:0]   SIZE_VAL = 'hA3C5_DD01
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              app_rst,
  input  logic              sys_rst,
  input  logic              sec_en,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_secure,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_ready,
  output logic              bus_err,
  input  logic [NPIN-1:0]   wake_pulse,
  output logic [DW-1:0]     ctrl_q,
  output logic [DW-1:0]     bkup_q,
  output logic [DW-1:0]     aux_q,
  output logic [NPIN-1:0]   wake_pol,
  output logic [2*NPIN-1:0] wake_pull,
  output logic [NPIN-1:0]   wake_flags,
  output logic [NPIN-1:0]   wake_secure
);
  // field layout needs NPIN <= 8 for DW = 32
  logic rst_any, rst_app, ns_filter, reject;
  logic slow, commit, release_clr, rd_take, clr_need, clr_done;
  sel_e sel;
  pol_e pol;
  logic [DW-1:0] rd_mux, cfg_rd;

  assign rst_any   = por_rst | app_rst | sys_rst;
  assign rst_app   = por_rst | app_rst;
  assign ns_filter = sec_en & ~bus_secure;
  assign reject    = bus_wr && ns_filter && (pol == P_GUARD);

  pmsr_decode #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .pol  (pol),
    .slow (slow)
  );

  pmsr_seq #(.WS(WS)) u_seq (
    .clk         (clk),
    .rst         (rst_any),
    .wr          (bus_wr),
    .rd          (bus_rd),
    .reject      (reject),
    .slow        (slow),
    .clr_need    (clr_need),
    .clr_done    (clr_done),
    .ready       (bus_ready),
    .err         (bus_err),
    .commit      (commit),
    .release_clr (release_clr),
    .rd_take     (rd_take)
  );

  pmsr_wake #(.NPIN(NPIN)) u_wake (
    .clk         (clk),
    .rst         (rst_app),
    .ns_filter   (ns_filter),
    .sel_cfg     (sel == S_WKCFG),
    .wr_cfg      (commit && sel == S_WKCFG),
    .wr_sec      (commit && sel == S_WKSEC),
    .clr_bits    (bus_wdata[NPIN-1:0]),
    .pol_bits    (bus_wdata[POL_LSB +: NPIN]),
    .pull_bits   (bus_wdata[PULL_LSB +: 2*NPIN]),
    .sec_bits    (bus_wdata[NPIN-1:0]),
    .wake_pulse  (wake_pulse),
    .release_clr (release_clr),
    .flags       (wake_flags),
    .secen       (wake_secure),
    .pol         (wake_pol),
    .pull        (wake_pull),
    .clr_need    (clr_need),
    .clr_done    (clr_done)
  );

  // system group
  always_ff @(posedge clk) begin
    if (rst_any) begin
      ctrl_q <= '0;
      aux_q  <= '0;
    end else if (commit) begin
      if (sel == S_CTRL) ctrl_q <= bus_wdata;
      if (sel == S_AUX)  aux_q  <= bus_wdata;
    end
  end

  // power-on group, gated by the unlock bit
  always_ff @(posedge clk) begin
    if (por_rst)                                   bkup_q <= '0;
    else if (commit && sel == S_BKUP && ctrl_q[0]) bkup_q <= bus_wdata;
  end

  always_comb begin
    cfg_rd = '0;
    for (int p = 0; p < NPIN; p++) begin
      cfg_rd[POL_LSB + p]       = wake_pol[p];
      cfg_rd[PULL_LSB + 2*p +: 2] = wake_pull[2*p +: 2];
    end
  end

  always_comb begin
    unique case (sel)
      S_CTRL:  rd_mux = ctrl_q;
      S_BKUP:  rd_mux = bkup_q;
      S_AUX:   rd_mux = aux_q;
      S_WKCFG: rd_mux = cfg_rd;
      S_WKFLG: rd_mux = DW'(wake_flags);
      S_WKSEC: rd_mux = DW'(wake_secure);
      S_VER:   rd_mux = VER_VAL;
      S_IDN:   rd_mux = IDN_VAL;
      S_SIZE:  rd_mux = SIZE_VAL;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_any) bus_rdata <= '0;
    else         bus_rdata <= rd_take ? rd_mux : '0;
  end

  // R7: a locked backup register does not move
  a_r7_locked_bkup: assert property (@(posedge clk) disable iff (por_rst)
    (commit && sel == S_BKUP && !ctrl_q[0]) |=> $stable(bkup_q));
  // R4: the open register takes the bus data on commit
  a_r4_aux_open: assert property (@(posedge clk) disable iff (rst_any)
    (commit && sel == S_AUX) |=> (aux_q == $past(bus_wdata)));
  // R3: an error response leaves the guarded registers untouched
  a_r3_err_no_change: assert property (@(posedge clk) disable iff (rst_any)
    bus_err |-> ($stable(ctrl_q) && $stable(bkup_q) && $stable(wake_secure)));
  // R10: a system reset leaves the backup register alone
  a_r10_sys_keeps_bkup: assert property (@(posedge clk) disable iff (por_rst)
    sys_rst |=> $stable(bkup_q));
endmodule

// File: tb/test_pm_secure_regs.sv
module test_pm_secure_regs;
  localparam int AW = 10, DW = 32, NPIN = 6, WS = 6;
  localparam logic [31:0] VER_E = 32'h0000_0012, IDN_E = 32'h0031_5057, SIZE_E = 32'hA3C5_DD01;
  localparam int L_FAST = 1, L_SLOW = WS + 1, L_CLR = WS + 2, L_PRIO = WS + 3;

  logic clk = 1'b0;
  logic por_rst = 1'b1, app_rst = 1'b1, sys_rst = 1'b1, sec_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_secure = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic bus_ready, bus_err;
  logic [NPIN-1:0] wake_pulse = '0;
  logic [DW-1:0] ctrl_q, bkup_q, aux_q;
  logic [NPIN-1:0] wake_pol, wake_flags, wake_secure;
  logic [2*NPIN-1:0] wake_pull;

  always #5 clk = ~clk;

  pm_secure_regs i_pm_secure_regs (
    .clk(clk), .por_rst(por_rst), .app_rst(app_rst), .sys_rst(sys_rst), .sec_en(sec_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_secure(bus_secure), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
    .wake_pulse(wake_pulse), .ctrl_q(ctrl_q), .bkup_q(bkup_q), .aux_q(aux_q),
    .wake_pol(wake_pol), .wake_pull(wake_pull), .wake_flags(wake_flags), .wake_secure(wake_secure)
  );

  typedef struct {
    logic [31:0] data;
    bit          cd;
    bit          err;
    int          lat;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, req_cyc = 0, nchk = 0, nfail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completion
  always @(negedge clk) begin
    if (bus_ready) begin
      if (q.size() == 0) chk(1'b0, "R5 unexpected ready", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(bus_err == e.err, {e.tag, " err"}, 32'(bus_err), 32'(e.err));
        chk((cyc - req_cyc) == e.lat, {e.tag, " latency"}, 32'(cyc - req_cyc), 32'(e.lat));
        if (e.cd) chk(bus_rdata == e.data, {e.tag, " rdata"}, bus_rdata, e.data);
      end
    end
  end

  task automatic acc(input bit w, input logic [AW-1:0] a, input logic [31:0] d, input bit s,
                     input bit cd, input logic [31:0] ex, input bit ee, input int lat, input string tag);
    exp_t e;
    @(negedge clk);
    e.data = ex; e.cd = cd; e.err = ee; e.lat = lat; e.tag = tag;
    q.push_back(e);
    bus_addr = a; bus_wdata = d; bus_secure = s; bus_wr = w; bus_rd = !w;
    req_cyc = cyc;
    do @(negedge clk); while (!bus_ready);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input bit s, input bit ee,
                    input int lat, input string tag);
    acc(1'b1, a, d, s, 1'b0, '0, ee, lat, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit s, input logic [31:0] ex, input string tag);
    acc(1'b0, a, '0, s, 1'b1, ex, 1'b0, L_FAST, tag);
  endtask

  task automatic pulse_wake(input logic [NPIN-1:0] v);
    @(negedge clk); wake_pulse = v;
    @(negedge clk); wake_pulse = '0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    por_rst = 1'b0; app_rst = 1'b0; sys_rst = 1'b0;

    // R1 reset values
    chk(ctrl_q == 0 && bkup_q == 0 && aux_q == 0, "R1 reg outputs", ctrl_q | bkup_q | aux_q, 0);
    chk({wake_pol, wake_pull, wake_flags, wake_secure} == 0, "R1 wake outputs", 32'(wake_pull), 0);
    rd(10'h00, 1, 0, "R1 ctrl");
    rd(10'h04, 1, 0, "R1 bkup");
    rd(10'h08, 1, 0, "R1 aux");
    rd(10'h0C, 1, 0, "R1 wkcfg");
    rd(10'h10, 1, 0, "R1 wkflag");
    rd(10'h14, 1, 0, "R1 wksec");

    // R11 identification words
    rd(10'h3F4, 0, VER_E, "R11 ver");
    rd(10'h3F8, 1, IDN_E, "R11 idn");
    rd(10'h3FC, 0, SIZE_E, "R11 size");
    wr(10'h3F8, 32'hFFFF_FFFF, 1, 0, L_FAST, "R11 write ignored");
    rd(10'h3F8, 1, IDN_E, "R11 idn after write");

    // R12 reserved space
    rd(10'h018, 1, 0, "R12 hole read");
    rd(10'h200, 0, 0, "R12 far hole read");
    rd(10'h001, 1, 0, "R12 unaligned read");
    wr(10'h100, 32'h1234_5678, 1, 0, L_FAST, "R12 hole write");
    rd(10'h100, 1, 0, "R12 hole read after write");

    // R5 latencies
    wr(10'h00, 32'h0000_0001, 1, 0, L_FAST, "R5 ctrl fast write");
    rd(10'h00, 1, 32'h1, "R5 ctrl readback");
    wr(10'h08, 32'h1234_5678, 1, 0, L_SLOW, "R5 aux slow write");
    rd(10'h08, 1, 32'h1234_5678, "R5 aux readback");

    // R7 backup lock
    wr(10'h04, 32'hCAFE_F00D, 1, 0, L_SLOW, "R7 unlocked write");
    rd(10'h04, 1, 32'hCAFE_F00D, "R7 unlocked readback");
    wr(10'h00, 32'h0, 1, 0, L_FAST, "R7 lock");
    wr(10'h04, 32'h1111_1111, 1, 0, L_SLOW, "R7 locked write silent");
    rd(10'h04, 1, 32'hCAFE_F00D, "R7 locked readback");
    chk(bkup_q == 32'hCAFE_F00D, "R7 bkup port", bkup_q, 32'hCAFE_F00D);
    wr(10'h00, 32'h1, 1, 0, L_FAST, "R7 unlock");

    // R3 guarded registers, R2 non-secure reads
    sec_en = 1'b1;
    wr(10'h00, 32'hFF, 0, 1, L_FAST, "R3 ctrl reject");
    rd(10'h00, 0, 32'h1, "R2 R3 ctrl nonsecure read");
    wr(10'h04, 32'h2222_2222, 0, 1, L_FAST, "R3 bkup reject");
    rd(10'h04, 0, 32'hCAFE_F00D, "R3 bkup unchanged");
    wr(10'h14, 32'h3F, 0, 1, L_FAST, "R3 wksec reject");
    rd(10'h14, 1, 0, "R3 wksec unchanged");
    wr(10'h14, 32'h05, 1, 0, L_SLOW, "R3 wksec secure write");
    rd(10'h14, 0, 32'h05, "R2 wksec nonsecure read");

    // R4 open register
    wr(10'h08, 32'hA5A5_A5A5, 0, 0, L_SLOW, "R4 aux nonsecure write");
    rd(10'h08, 0, 32'hA5A5_A5A5, "R4 aux readback");
    chk(aux_q == 32'hA5A5_A5A5, "R4 aux port", aux_q, 32'hA5A5_A5A5);

    // R6 per-pin masking (pins 0 and 2 protected)
    wr(10'h0C, 32'h0AAA_3F00, 1, 0, L_SLOW, "R6 secure cfg write");
    rd(10'h0C, 1, 32'h0AAA_3F00, "R6 cfg readback");
    wr(10'h0C, 32'h0, 0, 0, L_SLOW, "R6 filtered write");
    rd(10'h0C, 1, 32'h0022_0500, "R6 mixed result");
    chk(wake_pol == 6'b000101, "R6 pol port", 32'(wake_pol), 32'h05);
    sec_en = 1'b0;
    wr(10'h0C, 32'h0AAA_3F00, 0, 0, L_SLOW, "R6 unfiltered when disabled");
    rd(10'h0C, 0, 32'h0AAA_3F00, "R6 cfg restored");

    // R9 flags
    pulse_wake(6'b001011);
    rd(10'h10, 1, 32'h0B, "R9 flags set");
    wr(10'h10, 32'h0, 1, 0, L_FAST, "R9 flag write ignored");
    rd(10'h10, 1, 32'h0B, "R9 flags unchanged");

    // R8 clear handshake
    wr(10'h0C, 32'h0AAA_3F02, 1, 0, L_CLR, "R8 clear pin1");
    rd(10'h10, 1, 32'h09, "R8 pin1 cleared");
    rd(10'h0C, 1, 32'h0AAA_3F00, "R6 clear bits read zero");
    sec_en = 1'b1;
    wr(10'h0C, 32'h0AAA_3F3F, 0, 0, L_CLR, "R6 R8 filtered clear");
    rd(10'h10, 1, 32'h01, "R6 protected flag kept");
    sec_en = 1'b0;

    // R9 set beats clear at the commit edge
    fork
      wr(10'h0C, 32'h0AAA_3F01, 1, 0, L_PRIO, "R9 set priority latency");
      begin
        @(negedge clk);
        repeat (WS) @(negedge clk);
        wake_pulse = 6'b000001;
        @(negedge clk);
        wake_pulse = '0;
      end
    join
    rd(10'h10, 1, 32'h00, "R9 flag finally clear");

    // R10 reset groups
    pulse_wake(6'b100000);
    @(negedge clk); sys_rst = 1'b1;
    repeat (2) @(negedge clk); sys_rst = 1'b0;
    rd(10'h00, 1, 0, "R10 sys clears ctrl");
    rd(10'h08, 1, 0, "R10 sys clears aux");
    rd(10'h04, 1, 32'hCAFE_F00D, "R10 sys keeps bkup");
    rd(10'h0C, 1, 32'h0AAA_3F00, "R10 sys keeps wkcfg");
    rd(10'h14, 1, 32'h05, "R10 sys keeps wksec");
    rd(10'h10, 1, 32'h20, "R10 sys keeps flags");
    @(negedge clk); app_rst = 1'b1;
    repeat (2) @(negedge clk); app_rst = 1'b0;
    rd(10'h0C, 1, 0, "R10 app clears wkcfg");
    rd(10'h14, 1, 0, "R10 app clears wksec");
    rd(10'h10, 1, 0, "R10 app clears flags");
    rd(10'h04, 1, 32'hCAFE_F00D, "R10 app keeps bkup");
    @(negedge clk); por_rst = 1'b1;
    repeat (2) @(negedge clk); por_rst = 1'b0;
    rd(10'h04, 1, 0, "R10 por clears bkup");
    chk(bkup_q == 0, "R10 bkup port", bkup_q, 0);

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R5 pending completions", 32'(q.size()), 0);
    finish_run();
  end
endmodule